// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from reset to a usable state. It drives the command pins, clock enable, data mask and address bus for the whole start-up phase. Once that phase is over it raises a done flag, and the normal memory controller takes over the pins. The block has no inputs other than clock and reset. Everything it does follows from its parameters: the clock period, the length of the initial pause, the row-precharge and row-cycle times, the number of auto-refreshes, the mode-register fields, and the position of the refreshes relative to the mode write.

After reset the block sends only NOP commands, with clock enable and data mask held high, until the pause has elapsed. It then closes all banks with one precharge-all command. It issues the auto-refresh burst and the mode-register write in the order the parameter selects. The command after a precharge waits for the row-precharge time, the command after a refresh waits for the row-cycle time, and the command after the mode write waits a fixed number of cycles. Every nanosecond figure is turned into clock cycles by rounding up. A reset at any point restarts the sequence from the beginning.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, the outputs are: command NOP ({sdCsN,sdRasN,sdCasN,sdWeN} = 4'b0111), sdCke = 1, sdDqm = 1, sdAddr = 0 and initDone = 0.
- R2: The first non-NOP command appears right after rising clock edge number PAUSE_CYC, counting only edges at which rstN is high. PAUSE_CYC = ceil(PAUSE_NS*1000 / CLK_PERIOD_PS). Only NOPs are driven before it.
- R3: sdCke and sdDqm stay high for as long as initDone is low. Once initDone is high, sdCke stays high and sdDqm is low.
- R4: The first command is a precharge (4'b0010) with sdAddr bit 10 set, which selects all banks. No other sdAddr bit is set, and no second precharge is issued.
- R5: Command order is precharge, then REFRESH_COUNT refreshes (4'b0001), then one mode write (4'b0000) when REFRESH_FIRST = 1. When REFRESH_FIRST = 0 the order is precharge, mode write, then the refreshes. The mode write never comes before the precharge.
- R6: During the mode write, sdAddr carries the burst-length code in bits 2:0, the burst type in bit 3 (1 = interleaved) and the CAS latency in bits 6:4. All other bits are 0. During refreshes sdAddr is 0.
- R7: The gap from a precharge to the next command is exactly ceil(TRP_NS*1000/CLK_PERIOD_PS) cycles. From a refresh it is exactly ceil(TRC_NS*1000/CLK_PERIOD_PS) cycles. From the mode write it is exactly MRD_CYC cycles.
- R8: initDone rises exactly one gap after the last command, using that command's gap as defined in R7. It then stays high until reset, and only NOPs follow.
- R9: Exactly REFRESH_COUNT refresh commands are issued, so there are REFRESH_COUNT + 2 non-NOP commands in total.
- R10: A reset applied part-way through the sequence returns the outputs to the R1 state. The next sequence starts over in full, with R2 timing counted from the new reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sdCke | output | 1 | Clock enable to the memory |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdDqm | output | 1 | Data mask, held high during start-up |
| sdAddr | output | ADDR_W | Address bus: bit 10 for precharge-all, mode value during the mode write |
| initDone | output | 1 | High once start-up is complete |

## Verification
The bench builds two instances side by side. The first uses the default parameters: a 10 ns clock, a 200 µs pause of 20000 cycles, eight refreshes placed before the mode write, CAS latency 3 and sequential burst length 4. The second has a 500 ns pause, a 95 ns row cycle that rounds up to 10 cycles, nine refreshes placed after the mode write, and interleaved burst length 8 with CAS latency 2. The short pause of the second instance makes repeated random mid-sequence resets cheap to apply, and it covers the other command order, the rounding-up of a fractional cycle count and a different mode word.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command encoding on {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdCmdE;

  // Which spacing the wait timer loads after a command
  typedef enum logic [1:0] {
    SP_RP  = 2'd0,
    SP_RC  = 2'd1,
    SP_MRD = 2'd2
  } spaceSelE;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic     issuePre;
    logic     issueRef;
    logic     issueMrs;
    logic     loadTimer;
    spaceSelE spaceSel;
    logic     setDone;
  } initStrobeT;

  // Round a time in ns up to a whole number of clock cycles (at least one)
  function automatic int nsToCycles(input int ns, input int periodPs);
    longint num;
    longint cyc;
    num = longint'(ns) * 64'd1000;
    cyc = (num + longint'(periodPs) - 64'd1) / longint'(periodPs);
    if (cyc < 64'd1) cyc = 64'd1;
    return int'(cyc);
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int REFRESH_COUNT = 8,
  parameter bit REFRESH_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       timerZero,
  output initStrobeT strobe
);

  localparam int RCW = $clog2(REFRESH_COUNT + 1);
  localparam logic [RCW-1:0] LAST_REF = RCW'(REFRESH_COUNT - 1);

  typedef enum logic [2:0] {
    ST_PAUSE,  // waiting out the pause, precharge-all is next
    ST_REF,    // refresh burst in progress
    ST_MRS,    // mode write is next
    ST_FINAL,  // waiting out the spacing of the last command
    ST_DONE
  } stateE;

  localparam stateE AFTER_PRE  = REFRESH_FIRST ? ST_REF : ST_MRS;
  localparam stateE AFTER_REFS = REFRESH_FIRST ? ST_MRS : ST_FINAL;
  localparam stateE AFTER_MRS  = REFRESH_FIRST ? ST_FINAL : ST_REF;

  stateE          state, stateNext;
  logic [RCW-1:0] refCnt, refCntNext;

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    refCntNext = refCnt;
    unique case (state)
      ST_PAUSE: begin
        if (timerZero) begin
          strobe.issuePre  = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.spaceSel  = SP_RP;
          stateNext        = AFTER_PRE;
        end
      end
      ST_REF: begin
        if (timerZero) begin
          strobe.issueRef  = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.spaceSel  = SP_RC;
          refCntNext       = refCnt + 1'b1;
          if (refCnt == LAST_REF) stateNext = AFTER_REFS;
        end
      end
      ST_MRS: begin
        if (timerZero) begin
          strobe.issueMrs  = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.spaceSel  = SP_MRD;
          stateNext        = AFTER_MRS;
        end
      end
      ST_FINAL: begin
        if (timerZero) begin
          strobe.setDone = 1'b1;
          stateNext      = ST_DONE;
        end
      end
      default: stateNext = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_PAUSE;
      refCnt <= '0;
    end else begin
      state  <= stateNext;
      refCnt <= refCntNext;
    end
  end

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAUSE_CYC = 20000,
  parameter int TRP_CYC   = 2,
  parameter int TRC_CYC   = 9,
  parameter int MRD_CYC   = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  initStrobeT        strobe,
  output logic              timerZero,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdDqm,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              initDone
);

  localparam int MAX_CYC = maxOf(maxOf(PAUSE_CYC, TRP_CYC), maxOf(TRC_CYC, MRD_CYC));
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0]     PAUSE_LOAD = TW'(PAUSE_CYC - 1);
  localparam logic [TW-1:0]     TRP_LOAD   = TW'(TRP_CYC - 1);
  localparam logic [TW-1:0]     TRC_LOAD   = TW'(TRC_CYC - 1);
  localparam logic [TW-1:0]     MRD_LOAD   = TW'(MRD_CYC - 1);
  localparam logic [ADDR_W-1:0] ALL_BANKS  = ADDR_W'(1 << 10);

  logic [TW-1:0]     timer, spaceVal;
  sdCmdE             cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic              ckeQ, dqmQ, doneQ;

  always_comb begin
    unique case (strobe.spaceSel)
      SP_RP:   spaceVal = TRP_LOAD;
      SP_RC:   spaceVal = TRC_LOAD;
      default: spaceVal = MRD_LOAD;
    endcase
  end

  // One shared down-counter covers the pause and every command spacing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= PAUSE_LOAD;
    else if (strobe.loadTimer) timer <= spaceVal;
    else if (timer != '0)      timer <= timer - 1'b1;
  end

  assign timerZero = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      ckeQ  <= 1'b1;
      dqmQ  <= 1'b1;
      doneQ <= 1'b0;
    end else begin
      ckeQ <= 1'b1;
      if (strobe.issuePre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= ALL_BANKS;
      end else if (strobe.issueRef) begin
        cmdQ  <= CMD_REF;
        addrQ <= '0;
      end else if (strobe.issueMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= MODE_WORD;
      end else begin
        cmdQ  <= CMD_NOP;
        addrQ <= '0;
      end
      if (strobe.setDone) begin
        doneQ <= 1'b1;
        dqmQ  <= 1'b0;
      end
    end
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdQ;
  assign sdCke    = ckeQ;
  assign sdDqm    = dqmQ;
  assign sdAddr   = addrQ;
  assign initDone = doneQ;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int       CLK_PERIOD_PS     = 10000,
  parameter int       PAUSE_NS          = 200000,
  parameter int       TRP_NS            = 18,
  parameter int       TRC_NS            = 90,
  parameter int       MRD_CYC           = 2,
  parameter int       REFRESH_COUNT     = 8,
  parameter bit       REFRESH_FIRST     = 1'b1,
  parameter int       ADDR_W            = 13,
  parameter logic [2:0] BURST_LEN_CODE  = 3'd2,
  parameter bit       BURST_INTERLEAVED = 1'b0,
  parameter logic [2:0] CAS_LATENCY     = 3'd3
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdDqm,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              initDone
);

  localparam int PAUSE_CYC = nsToCycles(PAUSE_NS, CLK_PERIOD_PS);
  localparam int TRP_CYC   = nsToCycles(TRP_NS, CLK_PERIOD_PS);
  localparam int TRC_CYC   = nsToCycles(TRC_NS, CLK_PERIOD_PS);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({CAS_LATENCY, BURST_INTERLEAVED, BURST_LEN_CODE});

  initStrobeT strobe;
  logic       timerZero;

  sdram_init_ctrl #(
    .REFRESH_COUNT(REFRESH_COUNT),
    .REFRESH_FIRST(REFRESH_FIRST)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .timerZero(timerZero),
    .strobe   (strobe)
  );

  sdram_init_dp #(
    .ADDR_W   (ADDR_W),
    .PAUSE_CYC(PAUSE_CYC),
    .TRP_CYC  (TRP_CYC),
    .TRC_CYC  (TRC_CYC),
    .MRD_CYC  (MRD_CYC),
    .MODE_WORD(MODE_WORD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .timerZero(timerZero),
    .sdCke    (sdCke),
    .sdCsN    (sdCsN),
    .sdRasN   (sdRasN),
    .sdCasN   (sdCasN),
    .sdWeN    (sdWeN),
    .sdDqm    (sdDqm),
    .sdAddr   (sdAddr),
    .initDone (initDone)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W    = 13,
  parameter int PAUSE_CYC = 20000,
  parameter int TRP_CYC   = 2,
  parameter int TRC_CYC   = 9,
  parameter int MRD_CYC   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdCke,
  input logic              sdCsN,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic              sdWeN,
  input logic              sdDqm,
  input logic [ADDR_W-1:0] sdAddr,
  input logic              initDone
);

  localparam logic [3:0] K_NOP = 4'b0111;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_REF = 4'b0001;
  localparam logic [3:0] K_MRS = 4'b0000;
  localparam int SW = $clog2(PAUSE_CYC + 1);
  localparam logic [SW-1:0] PAUSE_S = SW'(PAUSE_CYC);
  localparam logic [15:0]   TRP_G   = 16'(TRP_CYC);
  localparam logic [15:0]   TRC_G   = 16'(TRC_CYC);
  localparam logic [15:0]   MRD_G   = 16'(MRD_CYC);

  logic [3:0]    cmd;
  logic [SW-1:0] sinceRst;
  logic [15:0]   gap;
  logic [3:0]    lastCmd;
  logic          preSeen;

  assign cmd = {sdCsN, sdRasN, sdCasN, sdWeN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      gap      <= '0;
      lastCmd  <= K_NOP;
      preSeen  <= 1'b0;
    end else begin
      if (sinceRst != PAUSE_S) sinceRst <= sinceRst + 1'b1;
      if (cmd != K_NOP) begin
        gap     <= 16'd1;
        lastCmd <= cmd;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 16'd1;
      end
      if (cmd == K_PRE) preSeen <= 1'b1;
    end
  end

  // R2: no command other than NOP before the pause has elapsed
  a_r2_pause_nop: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != K_NOP) |-> (sinceRst == PAUSE_S));

  // R3: clock enable and data mask high until done
  a_r3_cke_dqm_high: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (sdCke && sdDqm));

  // R4: a precharge always closes all banks
  a_r4_pre_all: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == K_PRE) |-> sdAddr[10]);

  // R5: the mode write comes only after the precharge
  a_r5_mrs_after_pre: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == K_MRS) |-> preSeen);

  // R6: refreshes carry a zero address
  a_r6_ref_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == K_REF) |-> (sdAddr == '0));

  // R7: minimum spacing after each command type
  a_r7_gap_after_pre: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd != K_NOP) && (lastCmd == K_PRE)) |-> (gap >= TRP_G));
  a_r7_gap_after_ref: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd != K_NOP) && (lastCmd == K_REF)) |-> (gap >= TRC_G));
  a_r7_gap_after_mrs: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd != K_NOP) && (lastCmd == K_MRS)) |-> (gap >= MRD_G));

  // R8: done is sticky and the bus stays quiet afterwards
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);
  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> ((cmd == K_NOP) && !sdDqm && sdCke));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W   (ADDR_W),
  .PAUSE_CYC(PAUSE_CYC),
  .TRP_CYC  (TRP_CYC),
  .TRC_CYC  (TRC_CYC),
  .MRD_CYC  (MRD_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sdCke   (sdCke),
  .sdCsN   (sdCsN),
  .sdRasN  (sdRasN),
  .sdCasN  (sdCasN),
  .sdWeN   (sdWeN),
  .sdDqm   (sdDqm),
  .sdAddr  (sdAddr),
  .initDone(initDone)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam int WATCHDOG = 40000;

  logic clk     = 1'b0;
  logic rstN    = 1'b0;
  logic rstAltN = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int wd     = 0;

  logic        cke   [2];
  logic        dqm   [2];
  logic        done  [2];
  logic [3:0]  cmd   [2];
  logic [12:0] addr  [2];
  logic        csN[2], rasN[2], casN[2], weN[2];

  sdram_init_seq u_sdram_init_seq (
    .clk(clk), .rstN(rstN), .sdCke(cke[0]), .sdCsN(csN[0]), .sdRasN(rasN[0]),
    .sdCasN(casN[0]), .sdWeN(weN[0]), .sdDqm(dqm[0]), .sdAddr(addr[0]),
    .initDone(done[0])
  );

  sdram_init_seq #(
    .PAUSE_NS(500), .TRC_NS(95), .REFRESH_COUNT(9), .REFRESH_FIRST(1'b0),
    .BURST_LEN_CODE(3'd3), .BURST_INTERLEAVED(1'b1), .CAS_LATENCY(3'd2)
  ) u_alt (
    .clk(clk), .rstN(rstAltN), .sdCke(cke[1]), .sdCsN(csN[1]), .sdRasN(rasN[1]),
    .sdCasN(casN[1]), .sdWeN(weN[1]), .sdDqm(dqm[1]), .sdAddr(addr[1]),
    .initDone(done[1])
  );

  assign cmd[0] = {csN[0], rasN[0], casN[0], weN[0]};
  assign cmd[1] = {csN[1], rasN[1], casN[1], weN[1]};

  // Trace of each instance
  int          cnt    [2];
  logic [3:0]  trCmd  [2][16];
  int          trCyc  [2][16];
  logic [12:0] trAddr [2][16];
  int          trN    [2];
  int          doneCyc[2];
  bit          bad3   [2];
  bit          bad8   [2];

  always @(posedge clk) begin
    cnt[0] <= rstN    ? cnt[0] + 1 : 0;
    cnt[1] <= rstAltN ? cnt[1] + 1 : 0;
  end

  task automatic record(input int k, input logic r);
    if (!r) begin
      trN[k]     = 0;
      doneCyc[k] = -1;
    end else begin
      if (cmd[k] != C_NOP) begin
        if (trN[k] < 16) begin
          trCmd[k][trN[k]]  = cmd[k];
          trCyc[k][trN[k]]  = cnt[k];
          trAddr[k][trN[k]] = addr[k];
        end
        trN[k]++;
      end
      if (done[k] && doneCyc[k] < 0) doneCyc[k] = cnt[k];
      if (!done[k] && !(cke[k] && dqm[k])) bad3[k] = 1'b1;
      if (done[k] && (cmd[k] != C_NOP || dqm[k] || !cke[k])) bad8[k] = 1'b1;
      if (doneCyc[k] >= 0 && !done[k]) bad8[k] = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    record(0, rstN);
    record(1, rstAltN);
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int ceilCyc(input int ns);
    return (ns * 1000 + 9999) / 10000;
  endfunction

  function automatic logic [12:0] modeWord(input int bl, input int bt, input int cl);
    return 13'((cl << 4) | (bt << 3) | bl);
  endfunction

  function automatic int spaceOf(input logic [3:0] c, input int trp, input int trc, input int mrd);
    if (c == C_PRE) return trp;
    if (c == C_REF) return trc;
    return mrd;
  endfunction

  task automatic checkResetState(input int k, input string tag);
    chk(cmd[k] == C_NOP, {tag, " command NOP in reset"}, int'(cmd[k]), int'(C_NOP));
    chk(cke[k] && dqm[k], {tag, " CKE and DQM high in reset"}, int'({cke[k], dqm[k]}), 3);
    chk(!done[k], {tag, " initDone low in reset"}, int'(done[k]), 0);
    chk(addr[k] == '0, {tag, " address zero in reset"}, int'(addr[k]), 0);
  endtask

  task automatic checkTrace(input int k, input string ctx, input int pause, input int nRef,
                            input bit refFirst, input int trp, input int trc, input int mrd,
                            input logic [12:0] mode);
    int         expCyc;
    logic [3:0] expCmd;
    logic [12:0] expAddr;
    chk(trN[k] == nRef + 2, {ctx, " R9 command count"}, trN[k], nRef + 2);
    expCyc = pause;
    for (int i = 0; i < nRef + 2 && i < trN[k] && i < 16; i++) begin
      if (i == 0)        expCmd = C_PRE;
      else if (refFirst) expCmd = (i == nRef + 1) ? C_MRS : C_REF;
      else               expCmd = (i == 1) ? C_MRS : C_REF;
      expAddr = (expCmd == C_PRE) ? 13'h400 : (expCmd == C_MRS) ? mode : 13'h000;
      chk(trCmd[k][i] == expCmd, $sformatf("%s R5 command %0d", ctx, i),
          int'(trCmd[k][i]), int'(expCmd));
      if (i == 0)
        chk(trCyc[k][i] == expCyc, {ctx, " R2 pause length"}, trCyc[k][i], expCyc);
      else
        chk(trCyc[k][i] == expCyc, $sformatf("%s R7 spacing before command %0d", ctx, i),
            trCyc[k][i], expCyc);
      chk(trAddr[k][i] == expAddr, $sformatf("%s R4/R6 address of command %0d", ctx, i),
          int'(trAddr[k][i]), int'(expAddr));
      expCyc += spaceOf(expCmd, trp, trc, mrd);
    end
    chk(doneCyc[k] == expCyc, {ctx, " R8 initDone cycle"}, doneCyc[k], expCyc);
    chk(!bad3[k], {ctx, " R3 CKE/DQM high before done"}, int'(bad3[k]), 0);
    chk(!bad8[k], {ctx, " R8 quiet and sticky after done"}, int'(bad8[k]), 0);
    chk(done[k] && !dqm[k] && cke[k], {ctx, " R3 final pin state"},
        int'({done[k], dqm[k], cke[k]}), 5);
  endtask

  // Watchdog: a hung run counts as a failure and still reports
  always @(posedge clk) begin
    wd++;
    if (wd > WATCHDOG) begin
      errors++;
      $display("FAIL R8 watchdog expired: initDone not reached");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    checkResetState(0, "main R1");
    checkResetState(1, "alt R1");
    rstN    = 1'b1;
    rstAltN = 1'b1;
    @(negedge clk);
    checkResetState(0, "main R1 first cycle after release");

    // Random mid-sequence resets on the short instance
    for (int a = 0; a < 4; a++) begin
      int d;
      d = 3 + int'($urandom % 150);
      repeat (d) @(negedge clk);
      rstAltN = 1'b0;
      @(negedge clk);
      checkResetState(1, "alt R10 abort");
      @(negedge clk);
      rstAltN = 1'b1;
    end
    // Directed: abort exactly at the precharge cycle
    while (cmd[1] != C_PRE) @(negedge clk);
    rstAltN = 1'b0;
    @(negedge clk);
    checkResetState(1, "alt R10 abort at precharge");
    rstAltN = 1'b1;

    while (doneCyc[0] < 0 || doneCyc[1] < 0) @(negedge clk);
    repeat (20) @(negedge clk);

    checkTrace(0, "main", ceilCyc(200000), 8, 1'b1, ceilCyc(18), ceilCyc(90), 2,
               modeWord(2, 0, 3));
    checkTrace(1, "alt R10 restart", ceilCyc(500), 9, 1'b0, ceilCyc(18), ceilCyc(95), 2,
               modeWord(3, 1, 2));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule